// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block takes a DRAM array from reset to a usable state and then keeps its contents alive. After reset it counts out a fixed power-up pause. It then runs a burst of warm-up refresh cycles. Only after that does it raise `init_done`, which lets the access controller start normal traffic.

From then on an interval timer marks each point at which a row refresh falls due. Each such point adds one to a count of owed refreshes, up to a fixed cap. While anything is owed, the sequencer raises `ref_req` towards the access controller. Once `ref_gnt` comes back, it drives the strobes itself and runs CAS-before-RAS refresh cycles back to back until nothing is owed. It then drops `ref_req` and leaves RAS, CAS and W high.

Each refresh cycle lowers all CAS strobes together before RAS falls, so the DRAM's internal row counter chooses the row and the address bus plays no part. W stays high the whole time. The data bus is never touched. Every delay is a parameter counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ras_n`, every bit of `cas_n` and `we_n` are 1, and `ref_req` and `init_done` are 0.
- R2: `ref_req` first becomes 1 exactly PAUSE_CYC+1 rising clock edges after reset is released, and no strobe moves before that.
- R3: After the pause, exactly WARMUP_CNT refresh cycles are run before `init_done` becomes 1. `init_done` then stays 1 until the next reset.
- R4: A refresh cycle starts, seen as the CAS strobes falling, only on an edge where `ref_req` and `ref_gnt` were both 1. While `ref_req` is 0, `ras_n` and all `cas_n` bits are 1.
- R5: All `cas_n` bits always carry the same value. In each refresh cycle, CAS is low for exactly T_CSR cycles before `ras_n` falls.
- R6: After `ras_n` falls, CAS stays low for exactly T_CHR cycles and then rises while RAS is still low. RAS stays low for exactly T_RAS cycles in total.
- R7: Between back-to-back refresh cycles, RAS and CAS are both high for exactly T_RP cycles.
- R8: `we_n` is 1 in every cycle.
- R9: Once `init_done` is 1, one refresh falls due every INTERVAL_CYC cycles. `ref_req` goes from 0 to 1 within two cycles of each due point, and with the grant given freely exactly one refresh is run per interval.
- R10: While the grant is withheld, owed refreshes build up to at most MAX_OWED, and further due points are dropped. On grant, exactly the owed number of cycles runs back to back, and then `ref_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Access controller hands the DRAM bus to the sequencer |
| ref_req | output | 1 | Sequencer asks for the DRAM bus |
| init_done | output | 1 | Power-up pause and warm-up refreshes are complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_W | Column strobes, active low, moved together |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The hardest state to reach from the ports is a full owed count at a known point relative to the interval timer. A burst that overlapped a fresh due point would run one extra cycle and hide a saturation fault. To get there, the bench counts cycles from the rise of `init_done` and withholds the grant for two intervals and then for ten. It gives the grant a few cycles after a due point, so the expected burst lengths of two and of the cap follow exactly from the cycle count. A strobe monitor measures the width of every CAS and RAS phase in every cycle, including the warm-up burst.

// File: rtl/drf_pkg.sv
package drf_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_WARM,
        PH_RUN
    } drf_phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSR,
        ST_RLO,
        ST_RHOLD,
        ST_PRE
    } drf_step_e;

endpackage

// File: rtl/drf_interval_timer.sv
module drf_interval_timer #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = en && (s_q.cnt == LAST);
        if (!en) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/drf_owed_ctr.sv
module drf_owed_ctr #(
    parameter int MAX_OWED = 4,
    parameter int LOAD_VAL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    input  logic take,
    output logic owed_nz
);
    localparam int CAP = (LOAD_VAL > MAX_OWED) ? LOAD_VAL : MAX_OWED;
    localparam int DW  = $clog2(CAP + 1);
    localparam logic [DW-1:0] MAXV  = DW'(MAX_OWED);
    localparam logic [DW-1:0] LOADV = DW'(LOAD_VAL);

    typedef struct packed {
        logic [DW-1:0] cnt;
    } owed_t;

    owed_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cnt = LOADV;
        end else begin
            if (take && (s_q.cnt != '0)) begin
                s_d.cnt = s_d.cnt - 1'b1;
            end
            if (tick && (take || (s_q.cnt < MAXV))) begin
                s_d.cnt = s_d.cnt + 1'b1;
            end
        end
        owed_nz = (s_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/drf_cbr_engine.sv
module drf_cbr_engine
    import drf_pkg::*;
#(
    parameter int CAS_W = 4,
    parameter int T_CSR = 2,
    parameter int T_CHR = 1,
    parameter int T_RAS = 6,
    parameter int T_RP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend,
    input  logic             gnt,
    output logic             req,
    output logic             take,
    output logic             busy,
    output logic             ras_n,
    output logic [CAS_W-1:0] cas_n,
    output logic             we_n
);
    localparam int T_RHOLD = T_RAS - T_CHR;
    localparam int M1   = (T_CSR > T_CHR) ? T_CSR : T_CHR;
    localparam int M2   = (T_RHOLD > T_RP) ? T_RHOLD : T_RP;
    localparam int LMAX = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(LMAX + 1);
    localparam logic [CW-1:0] L_CSR = CW'(T_CSR - 1);
    localparam logic [CW-1:0] L_CHR = CW'(T_CHR - 1);
    localparam logic [CW-1:0] L_RHD = CW'(T_RHOLD - 1);
    localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);

    typedef struct packed {
        drf_step_e     step;
        logic [CW-1:0] cnt;
        logic          req;
    } eng_t;

    eng_t s_d, s_q;
    logic last;

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        unique case (s_q.step)
            ST_CSR:   last = (s_q.cnt == L_CSR);
            ST_RLO:   last = (s_q.cnt == L_CHR);
            ST_RHOLD: last = (s_q.cnt == L_RHD);
            ST_PRE:   last = (s_q.cnt == L_RP);
            default:  last = 1'b0;
        endcase
        s_d.cnt = last ? '0 : s_q.cnt + 1'b1;

        unique case (s_q.step)
            ST_IDLE: begin
                s_d.cnt = '0;
                s_d.req = pend;
                if (pend && s_q.req && gnt) begin
                    s_d.step = ST_CSR;
                    s_d.req  = 1'b1;
                    take     = 1'b1;
                end
            end
            ST_CSR:   if (last) s_d.step = ST_RLO;
            ST_RLO:   if (last) s_d.step = ST_RHOLD;
            ST_RHOLD: if (last) s_d.step = ST_PRE;
            ST_PRE: begin
                if (last) begin
                    if (pend && gnt) begin
                        s_d.step = ST_CSR;
                        take     = 1'b1;
                    end else begin
                        s_d.step = ST_IDLE;
                        s_d.req  = pend;
                    end
                end
            end
            default: s_d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.step <= ST_IDLE;
            s_q.cnt  <= '0;
            s_q.req  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req   = s_q.req;
    assign busy  = (s_q.step != ST_IDLE);
    assign ras_n = !((s_q.step == ST_RLO) || (s_q.step == ST_RHOLD));
    assign cas_n = {CAS_W{!((s_q.step == ST_CSR) || (s_q.step == ST_RLO))}};
    assign we_n  = 1'b1;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import drf_pkg::*;
#(
    parameter int CAS_W        = 4,
    parameter int PAUSE_CYC    = 20000,
    parameter int WARMUP_CNT   = 8,
    parameter int INTERVAL_CYC = 1560,
    parameter int MAX_OWED     = 4,
    parameter int T_CSR        = 2,
    parameter int T_CHR        = 1,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             init_done,
    output logic             ras_n,
    output logic [CAS_W-1:0] cas_n,
    output logic             we_n
);
    localparam int PW = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(PAUSE_CYC - 1);

    typedef struct packed {
        drf_phase_e    phase;
        logic [PW-1:0] pcnt;
    } top_t;

    top_t s_d, s_q;
    logic load, tick, take, owed_nz, busy;

    always_comb begin
        s_d  = s_q;
        load = 1'b0;
        unique case (s_q.phase)
            PH_PAUSE: begin
                if (s_q.pcnt == P_LAST) begin
                    load      = 1'b1;
                    s_d.phase = PH_WARM;
                    s_d.pcnt  = '0;
                end else begin
                    s_d.pcnt = s_q.pcnt + 1'b1;
                end
            end
            PH_WARM: if (!owed_nz && !busy) s_d.phase = PH_RUN;
            default: s_d.phase = PH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_PAUSE;
            s_q.pcnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign init_done = (s_q.phase == PH_RUN);

    drf_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(init_done), .tick(tick)
    );

    drf_owed_ctr #(.MAX_OWED(MAX_OWED), .LOAD_VAL(WARMUP_CNT)) u_owed (
        .clk(clk), .rst_n(rst_n), .load(load), .tick(tick), .take(take),
        .owed_nz(owed_nz)
    );

    drf_cbr_engine #(
        .CAS_W(CAS_W), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .pend(owed_nz), .gnt(ref_gnt),
        .req(ref_req), .take(take), .busy(busy),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );
endmodule

// File: rtl/drf_refresh_checker.sv
module drf_refresh_checker #(
    parameter int CAS_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_gnt,
    input logic             ref_req,
    input logic             init_done,
    input logic             ras_n,
    input logic [CAS_W-1:0] cas_n
);
    a_r4_idle_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_req |-> (ras_n && (cas_n == '1)));

    a_r4_start_granted: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n[0]) |-> ($past(ref_gnt) && $past(ref_req)));

    a_r5_cas_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n == '0) || (cas_n == '1));

    a_r5_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ((cas_n == '0) && ($past(cas_n) == '0)));

    a_r6_cas_rises_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n[0]) |-> !ras_n);

    a_r3_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

bind dram_refresh_seq drf_refresh_checker #(.CAS_W(CAS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n)
);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;
    localparam int CAS_W = 4;
    localparam int PAUSE = 20;
    localparam int WARM  = 8;
    localparam int IV    = 60;
    localparam int MAXO  = 4;
    localparam int TCSR  = 2;
    localparam int TCHR  = 3;
    localparam int TRAS  = 6;
    localparam int TRP   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_gnt = 1'b0;
    logic ref_gnt, ref_req, init_done, ras_n, we_n;
    logic [CAS_W-1:0] cas_n;

    int checks = 0;
    int errors = 0;
    int refreshes = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign ref_gnt = auto_gnt & ref_req;

    dram_refresh_seq #(
        .CAS_W(CAS_W), .PAUSE_CYC(PAUSE), .WARMUP_CNT(WARM), .INTERVAL_CYC(IV),
        .MAX_OWED(MAXO), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
    endtask

    // strobe monitor
    logic p_ras = 1'b1, p_cas = 1'b1, p_gnt = 1'b0, p_req = 1'b0;
    int csr_n = 0, chr_n = 0, ras_lo = 0, pre_n = 0;
    bit pre_on = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(we_n === 1'b1, "R8 we_n high", int'(we_n), 1);
            check((cas_n == '0) || (cas_n == '1), "R5 cas uniform", int'(cas_n), 0);
            if (!ref_req)
                check(ras_n && (cas_n == '1), "R4 idle strobes without req", int'(ras_n), 1);
            if (p_cas && !cas_n[0] && ras_n) begin
                check(p_gnt && p_req, "R4 start only when granted", int'(p_gnt), 1);
                csr_n = 1;
            end else if (!cas_n[0] && ras_n) begin
                csr_n++;
            end
            if (p_ras && !ras_n) begin
                refreshes++;
                check(csr_n == TCSR, "R5 cas lead before ras", csr_n, TCSR);
                if (pre_on) check(pre_n == TRP, "R7 precharge gap", pre_n, TRP);
                pre_on = 1'b0;
                ras_lo = 1;
                chr_n  = cas_n[0] ? 0 : 1;
            end else if (!ras_n) begin
                ras_lo++;
                if (!cas_n[0]) chr_n++;
            end
            if (!p_ras && ras_n) begin
                check(ras_lo == TRAS, "R6 ras low width", ras_lo, TRAS);
                check(chr_n == TCHR, "R6 cas hold after ras", chr_n, TCHR);
                pre_on = 1'b1;
                pre_n  = 1;
            end else if (pre_on && ras_n && cas_n[0]) begin
                pre_n++;
            end
            if (!ref_req) pre_on = 1'b0;
        end
        p_ras = ras_n;
        p_cas = cas_n[0];
        p_gnt = ref_gnt;
        p_req = ref_req;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int rc;
        repeat (3) @(negedge clk);
        // R1 reset values
        check(ras_n === 1'b1, "R1 ras_n in reset", int'(ras_n), 1);
        check(cas_n === '1, "R1 cas_n in reset", int'(cas_n), 15);
        check(we_n === 1'b1, "R1 we_n in reset", int'(we_n), 1);
        check(ref_req === 1'b0, "R1 ref_req in reset", int'(ref_req), 0);
        check(init_done === 1'b0, "R1 init_done in reset", int'(init_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ref_req === 1'b0 && ras_n && (cas_n == '1), "R1 first cycle after reset",
              int'(ref_req), 0);

        // R2 pause length
        n = 1;
        while (!ref_req && n < PAUSE + 50) begin
            @(negedge clk);
            n++;
        end
        check(n == PAUSE + 1, "R2 pause length", n, PAUSE + 1);
        check(refreshes == 0, "R2 no strobe during pause", refreshes, 0);

        // R4 grant withheld
        repeat (5) @(negedge clk);
        check(ras_n && (cas_n == '1) && ref_req, "R4 wait for grant", int'(ras_n), 1);
        auto_gnt = 1'b1;

        // R3 warm-up
        n = 0;
        while (!init_done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(init_done === 1'b1, "R3 init_done rises", int'(init_done), 1);
        check(refreshes == WARM, "R3 warm-up count", refreshes, WARM);
        check(ref_req === 1'b0, "R10 req dropped after warm-up", int'(ref_req), 0);

        // R9 / R10 owed refreshes, grant withheld
        auto_gnt = 1'b0;
        cyc = 0;
        while (cyc < IV - 3) step();
        check(ref_req === 1'b0, "R9 no req before due point", int'(ref_req), 0);
        while (cyc < IV + 3) step();
        check(ref_req === 1'b1, "R9 req after due point", int'(ref_req), 1);
        while (cyc < 2 * IV + 5) step();
        rc = refreshes;
        auto_gnt = 1'b1;
        while (cyc < 2 * IV + 40) step();
        check(refreshes - rc == 2, "R10 two owed refreshes", refreshes - rc, 2);
        check(ref_req === 1'b0 && ras_n && (cas_n == '1), "R10 idle after burst",
              int'(ref_req), 0);
        check(init_done === 1'b1, "R3 init_done stays", int'(init_done), 1);

        auto_gnt = 1'b0;
        while (cyc < 12 * IV + 5) step();
        rc = refreshes;
        auto_gnt = 1'b1;
        while (cyc < 12 * IV + 57) step();
        check(refreshes - rc == MAXO, "R10 saturated burst", refreshes - rc, MAXO);
        check(ref_req === 1'b0, "R10 req drops after burst", int'(ref_req), 0);

        // R9 steady rate
        while (cyc < 13 * IV + 30) step();
        rc = refreshes;
        while (cyc < 23 * IV + 30) step();
        check(refreshes - rc == 10, "R9 one refresh per interval", refreshes - rc, 10);
        check(ref_req === 1'b0 && ras_n && (cas_n == '1) && we_n, "R4 idle at end",
              int'(ref_req), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule